// File: doc/BRIEF.md
# Self-Timed Word Program Sequencer

This block sits behind a serial memory slave and owns the programming phase of a word write. The slave hands it one accepted write as a single-cycle request that carries an address and a 16-bit word. The sequencer then waits a short, fixed settle interval. After that it pulls the ready/busy line low and counts out a self-timed programming period. When the period ends it issues one write strobe toward the storage array and releases busy. While a write is in flight, a command-accept inhibit tells the slave to refuse new commands. The inhibit stays up after ready returns and drops only when chip select is raised again.

The write-control input can kill a write at any time. If it is high before programming begins, the write is dropped and the stored word is left as it was. If it goes high during programming, the cycle stops at once and the word is filled with an all-ones pattern, which stands in for undefined content. An abort pulse with a qualifier bit tells the two cases apart. Chip select has no effect on a running program cycle. A falling chip select with the serial clock low routes the live ready/busy level onto the slave's data output.

Top module: `selftimed_write_seq`

## Requirements
- R1: After reset, rdy_busy is 1, cmd_inhibit is 0, mem_we is 0, stat_oe is 0 and abort_pulse is 0.
- R2: A write request accepted in idle with wc low keeps rdy_busy at 1 for exactly ARM_CYCLES clock cycles after the accepting edge, and then drives it to 0.
- R3: rdy_busy stays 0 for exactly PROG_CYCLES cycles. In the cycle it returns to 1, mem_we is 1 for one cycle, with mem_addr and mem_wdata equal to the requested address and word.
- R4: cmd_inhibit is 1 from the accepting edge until idle is re-entered. A write request seen while cmd_inhibit is 1 is ignored: it produces no busy and no strobe, and the stored word is unchanged.
- R5: wc high together with the request, or during any settle cycle, cancels the write. On the next cycle abort_pulse=1, abort_mid=0, mem_we=0 and cmd_inhibit=0, and the addressed word keeps its old value.
- R6: wc high during programming ends it on the next edge. In that cycle abort_pulse=1, abort_mid=1, rdy_busy=1, and mem_we=1 with mem_wdata all ones (16'hFFFF).
- R7: The cs_n level during the settle and programming phases does not change the busy timing or the committed word.
- R8: While a write is outstanding, a 1-to-0 transition of cs_n sampled with sk=0 sets stat_oe on the next cycle. While stat_oe is 1, stat_bit shows the ready/busy level: 0 means busy, 1 means ready. stat_oe clears when cs_n is 1 or when the block returns to idle.
- R9: After ready has returned, cmd_inhibit stays 1 while cs_n is 0. It falls on the cycle after cs_n is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | One-cycle write request from the serial slave |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Word to program |
| wc | input | 1 | Write-control level, high aborts |
| cs_n | input | 1 | Chip select level, active low |
| sk | input | 1 | Serial clock level, used to qualify the status display |
| rdy_busy | output | 1 | 1 = ready, 0 = programming |
| cmd_inhibit | output | 1 | 1 = slave must not accept a new command |
| mem_we | output | 1 | One-cycle write strobe to the array |
| mem_addr | output | ADDR_W | Array address for the strobe |
| mem_wdata | output | 16 | Array data for the strobe |
| stat_oe | output | 1 | Serial data output should show status |
| stat_bit | output | 1 | Status level for the serial data output |
| abort_pulse | output | 1 | One-cycle pulse when a write is killed |
| abort_mid | output | 1 | Qualifies abort_pulse: 1 = killed during programming |

## Verification
The bench places wc in every settle cycle, including the last one before busy falls, and in every programming cycle. This includes the final cycle, where the timer expiry and the abort arrive together. A design that starts programming one cycle early, or gives expiry priority over abort, would write the real word instead of cancelling, or commit instead of corrupting. Requests issued while the block is inhibited must leave memory and busy untouched; a leaky accept would rewrite a word. Toggling cs_n mid-cycle and then dropping it with sk low checks two things: chip select must not disturb timing, and the status display must track the transition from busy to ready rather than latch a stale level.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_PROG = 2'd2,
        ST_DONE = 2'd3
    } wseq_state_e;

    typedef struct packed {
        logic commit;
        logic kill_mid;
        logic kill_clean;
    } wseq_evt_t;

    function automatic word_t corrupt_word();
        return '1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wseq_timer.sv
module wseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
    import wseq_pkg::*;
#(
    parameter int ARM_CYCLES  = 4,
    parameter int PROG_CYCLES = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_req,
    input  logic        wc,
    input  logic        cs_n,
    output wseq_state_e state_q,
    output wseq_state_e state_d,
    output logic        capture,
    output wseq_evt_t   evt
);
    localparam int CW = $clog2(max2(ARM_CYCLES, PROG_CYCLES) + 1);
    localparam logic [CW-1:0] ARM_LOAD  = CW'(ARM_CYCLES - 1);
    localparam logic [CW-1:0] PROG_LOAD = CW'(PROG_CYCLES - 1);

    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_dec;
    logic          t_zero;

    wseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        t_dec   = 1'b0;
        capture = 1'b0;
        evt     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req) begin
                    if (wc) begin
                        evt.kill_clean = 1'b1;
                    end else begin
                        capture = 1'b1;
                        t_load  = 1'b1;
                        t_val   = ARM_LOAD;
                        state_d = ST_ARM;
                    end
                end
            end
            ST_ARM: begin
                if (wc) begin
                    evt.kill_clean = 1'b1;
                    state_d        = ST_IDLE;
                end else if (t_zero) begin
                    t_load  = 1'b1;
                    t_val   = PROG_LOAD;
                    state_d = ST_PROG;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_PROG: begin
                if (wc) begin
                    evt.kill_mid = 1'b1;
                    state_d      = ST_DONE;
                end else if (t_zero) begin
                    evt.commit = 1'b1;
                    state_d    = ST_DONE;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_DONE: begin
                if (cs_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wseq_status.sv
module wseq_status (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sk,
    input  logic keep,
    input  logic rdy,
    output logic oe,
    output logic level
);
    logic cs_q;
    logic oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b1;
            oe_q <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (!keep || cs_n) begin
                oe_q <= 1'b0;
            end else if (cs_q && !sk) begin
                oe_q <= 1'b1;
            end
        end
    end

    assign oe    = oe_q;
    assign level = oe_q ? rdy : 1'b1;
endmodule

// File: rtl/selftimed_write_seq.sv
module selftimed_write_seq
    import wseq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int ARM_CYCLES  = 4,
    parameter int PROG_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wc,
    input  logic              cs_n,
    input  logic              sk,
    output logic              rdy_busy,
    output logic              cmd_inhibit,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              stat_oe,
    output logic              stat_bit,
    output logic              abort_pulse,
    output logic              abort_mid
);
    wseq_state_e       state_q;
    wseq_state_e       state_d;
    logic              capture;
    wseq_evt_t         evt;
    logic [ADDR_W-1:0] addr_q;
    word_t             data_q;
    logic              we_q;
    logic [ADDR_W-1:0] maddr_q;
    word_t             mdata_q;
    logic              abt_q;
    logic              abt_mid_q;

    wseq_ctrl #(
        .ARM_CYCLES  (ARM_CYCLES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wc      (wc),
        .cs_n    (cs_n),
        .state_q (state_q),
        .state_d (state_d),
        .capture (capture),
        .evt     (evt)
    );

    assign rdy_busy    = (state_q != ST_PROG);
    assign cmd_inhibit = (state_q != ST_IDLE);

    wseq_status u_status (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .sk    (sk),
        .keep  (state_d != ST_IDLE),
        .rdy   (rdy_busy),
        .oe    (stat_oe),
        .level (stat_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= 1'b0;
            maddr_q   <= '0;
            mdata_q   <= '0;
            abt_q     <= 1'b0;
            abt_mid_q <= 1'b0;
        end else begin
            we_q      <= evt.commit | evt.kill_mid;
            abt_q     <= evt.kill_mid | evt.kill_clean;
            abt_mid_q <= evt.kill_mid;
            if (evt.commit | evt.kill_mid) begin
                maddr_q <= addr_q;
                mdata_q <= evt.kill_mid ? corrupt_word() : data_q;
            end
        end
    end

    assign mem_we      = we_q;
    assign mem_addr    = maddr_q;
    assign mem_wdata   = mdata_q;
    assign abort_pulse = abt_q;
    assign abort_mid   = abt_mid_q;
endmodule

// File: rtl/wseq_checker.sv
module wseq_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sk,
    input logic              rdy_busy,
    input logic              cmd_inhibit,
    input logic              mem_we,
    input logic [15:0]       mem_wdata,
    input logic              stat_oe,
    input logic              abort_pulse,
    input logic              abort_mid
);
    assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_busy) |-> $past(cmd_inhibit));

    assert_busy_inhibits_R4: assert property (@(posedge clk) disable iff (rst)
        !rdy_busy |-> cmd_inhibit);

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    assert_clean_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
        (abort_pulse && !abort_mid) |-> (!mem_we && !cmd_inhibit));

    assert_mid_corrupts_R6: assert property (@(posedge clk) disable iff (rst)
        (abort_pulse && abort_mid) |-> (mem_we && mem_wdata == 16'hFFFF && rdy_busy));

    assert_status_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_oe) |-> $past(!cs_n && !sk));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_inhibit |-> !stat_oe);
endmodule

bind selftimed_write_seq wseq_checker #(.ADDR_W(ADDR_W)) u_wseq_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .sk          (sk),
    .rdy_busy    (rdy_busy),
    .cmd_inhibit (cmd_inhibit),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .stat_oe     (stat_oe),
    .abort_pulse (abort_pulse),
    .abort_mid   (abort_mid)
);

// File: tb/selftimed_write_seq_bench.sv
`timescale 1ns/1ps
module selftimed_write_seq_bench;
    localparam int AW = 8;
    localparam int A  = 3;
    localparam int P  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          wc = 1'b0;
    logic          cs_n = 1'b1;
    logic          sk = 1'b0;
    logic          rdy_busy, cmd_inhibit, mem_we, stat_oe, stat_bit, abort_pulse, abort_mid;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;

    logic [15:0] bmem [2**AW];
    logic [15:0] emem [2**AW];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    selftimed_write_seq #(.ADDR_W(AW), .ARM_CYCLES(A), .PROG_CYCLES(P)) u_selftimed_write_seq (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wc(wc), .cs_n(cs_n), .sk(sk), .rdy_busy(rdy_busy), .cmd_inhibit(cmd_inhibit),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .stat_oe(stat_oe),
        .stat_bit(stat_bit), .abort_pulse(abort_pulse), .abort_mid(abort_mid)
    );

    always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] expect_word(input int mode, input logic [15:0] d,
                                                input logic [15:0] old);
        if (mode == 0) return d;
        if (mode == 2) return 16'hFFFF;
        return old;
    endfunction

    // mode 0: completes, 1: clean cancel at settle cycle k, 2: abort at program cycle k, 3: wc with request
    task automatic run_op(input logic [AW-1:0] a, input logic [15:0] d, input int mode,
                          input int k, input bit show);
        cs_n = 1'b0; sk = 1'b0;
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_req = 1'b1;
        wc = (mode == 3);
        @(negedge clk);
        wr_req = 1'b0;
        if (mode == 3) begin
            chk("R5 idle cancel abort", {abort_pulse, abort_mid, mem_we, cmd_inhibit}, 4'b1000);
            wc = 1'b0;
        end else begin
            for (int t = 1; t <= A + P + 1; t++) begin
                if (mode == 0) begin
                    if (t == A)         chk("R2 ready before settle end", rdy_busy, 1);
                    if (t == A + 1)     chk("R2 busy after settle", rdy_busy, 0);
                    if (t == A + P)     chk("R3 busy last cycle", rdy_busy, 0);
                    if (show && t == A + 4)
                        chk("R8 status shows busy", {stat_oe, stat_bit}, 2'b10);
                    if (t == A + P + 1) begin
                        chk("R3 ready and strobe", {rdy_busy, mem_we}, 2'b11);
                        chk("R3 strobe addr", mem_addr, a);
                        chk("R3 strobe data", mem_wdata, d);
                        if (show) chk("R8 status shows ready", {stat_oe, stat_bit}, 2'b11);
                        break;
                    end
                    if (show && t == 2)     cs_n = 1'b1;  // R7: cs high mid-cycle
                    if (show && t == A + 3) cs_n = 1'b0;  // falling with sk low
                end else if (mode == 1) begin
                    if (t == k + 1) begin
                        chk("R5 settle cancel",
                            {abort_pulse, abort_mid, mem_we, cmd_inhibit, rdy_busy}, 5'b10001);
                        break;
                    end
                    if (t == k) wc = 1'b1;
                end else begin
                    if (t == k + 1) begin
                        chk("R6 program abort",
                            {abort_pulse, abort_mid, mem_we, rdy_busy}, 4'b1111);
                        chk("R6 corrupt data", mem_wdata, 16'hFFFF);
                        break;
                    end
                    if (t == k) wc = 1'b1;
                end
                @(negedge clk);
            end
            wc = 1'b0;
        end
        emem[a] = expect_word(mode, d, emem[a]);
        if (mode == 0 || mode == 2) begin
            chk("R9 inhibit held while cs low", cmd_inhibit, 1);
            wr_data = ~d; wr_req = 1'b1;
            @(negedge clk);
            wr_req = 1'b0;
            chk("R4 ignored request", {rdy_busy, mem_we, cmd_inhibit}, 3'b101);
            @(negedge clk);
            chk("R4 ignored request stays ready", rdy_busy, 1);
            cs_n = 1'b1;
            @(negedge clk);
            chk("R9 idle after cs high", {cmd_inhibit, stat_oe}, 2'b00);
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk(mode == 0 ? "R3 stored word" : (mode == 2 ? "R6 stored word" : "R5 word kept"),
            bmem[a], emem[a]);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 2**AW; i++) begin
            bmem[i] = 16'h0000;
            emem[i] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", {rdy_busy, cmd_inhibit, mem_we, stat_oe, abort_pulse}, 5'b10000);

        run_op(8'h10, 16'hA5C3, 0, 0, 1'b1);
        run_op(8'h10, 16'h1234, 1, A, 1'b0);      // cancel in last settle cycle
        run_op(8'h11, 16'h5555, 1, 1, 1'b0);      // cancel in first settle cycle
        run_op(8'h10, 16'h0F0F, 3, 0, 1'b0);      // wc high with the request
        run_op(8'h12, 16'h0001, 0, 0, 1'b0);
        run_op(8'h12, 16'h7777, 2, A + P, 1'b0);  // abort on the expiry cycle
        run_op(8'h13, 16'h2222, 2, A + 1, 1'b0);  // abort on first program cycle

        for (int n = 0; n < 40; n++) begin
            int mode;
            int k;
            mode = $urandom_range(0, 3);
            k = 0;
            if (mode == 1) k = $urandom_range(1, A);
            if (mode == 2) k = $urandom_range(A + 1, A + P);
            run_op(AW'($urandom_range(0, 2**AW - 1)), 16'($urandom),
                   mode, k, (mode == 0) && ($urandom_range(0, 1) == 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule